// File: doc/BRIEF.md
# Receive FIFO Hysteresis Flow Controller

This block turns a receive FIFO fill count into a modem-style "ready to receive" request. The request has hysteresis. It is withdrawn once the count climbs to a high threshold. It comes back only after the count has drained to a low threshold. Between the two thresholds it keeps its last state.

The thresholds come from one of two sources:
- **Coarse mode:** a 4-bit trigger-select field that indexes a fixed table of threshold pairs. This mode is used while four extended level registers are all zero.
- **Fine mode:** a dedicated high/low register pair, which allows byte-granular settings. This mode is used as soon as any of the four extended registers is non-zero.

A swap bit moves the request onto the alternate modem pin. The same bit takes the peer's clear-to-send from the alternate input.

The block also raises a receive-level interrupt flag when the count reaches a receive trigger level. It reports whether the FIFO still has room. Reception is never stopped by the flow request itself; only a full FIFO stops it. The FIFO storage, the serializer and the register bus live outside this block.

Top module: `rx_flow_ctrl`

## Requirements
- R1: While `rst` is high, the outputs take these values at each clock edge: `rts_n`=0, `dtr_n`=1, `tx_clear_n`=1 and `rx_irq`=0. The internal flow state is "asserted" (request on).
- R2: Fine mode is active when any of `tx_lvl`, `rx_lvl`, `flow_hi` or `flow_lo` is non-zero. In fine mode the high threshold is `flow_hi` and the low threshold is `flow_lo`. When all four are zero, coarse mode is active and the thresholds come from `trig_sel`.
- R3: In coarse mode, `trig_sel[1:0]` selects the (high, low) threshold pair as follows: 0 gives (8, 4), 1 gives (16, 8), 2 gives (56, 32) and 3 gives (60, 48).
- R4: With `flow_en`=1, a count greater than or equal to the high threshold withdraws the request (the active pin goes to 1) at the next clock edge.
- R5: With `flow_en`=1, a count at or below the low threshold restores the request (the active pin goes to 0) at the next clock edge. A count strictly between the two thresholds leaves the request unchanged.
- R6: With `flow_en`=0, the request is held asserted (the active pin is 0) from the next clock edge, whatever the count.
- R7: With `pin_swap`=0, the request drives `rts_n` and `dtr_n` is held at 1. With `pin_swap`=1, the request drives `dtr_n` and `rts_n` is held at 1. Both pins are registered, so at most one of them is low at any time.
- R8: `tx_clear_n` is a registered copy of `cts_n` when `pin_swap`=0, and of `dsr_n` when `pin_swap`=1. It follows the input one clock later.
- R9: `rx_irq` is the registered result of comparing the count with the receive trigger (count greater than or equal to trigger). The trigger depends on the mode:
  - In coarse mode, `trig_sel[3:2]` selects the trigger: 0 gives 8, 1 gives 16, 2 gives 56 and 3 gives 60.
  - In fine mode, the trigger is `rx_lvl`, and a value of 0 is treated as 1.
- R10: `rx_space` is combinational. It is 1 whenever the count is below `DEPTH` (128 by default), regardless of the flow request state.
- R11: Thresholds are honoured at every value from 1 to 128, including a high threshold of 128 and a low threshold of 1.
- R12: If the high threshold is less than or equal to the low threshold, the high comparison takes priority. Any count at or above the high threshold withdraws the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W (8) | Current receive FIFO fill count, 0..DEPTH |
| flow_en | input | 1 | Hardware flow control enable |
| pin_swap | input | 1 | Move request/clear function to the alternate modem pins |
| trig_sel | input | 4 | Coarse trigger field: [1:0] selects the threshold pair, [3:2] selects the receive trigger |
| tx_lvl | input | REG_W (8) | Extended transmit level register (used only for mode selection) |
| rx_lvl | input | REG_W (8) | Extended receive trigger level |
| flow_hi | input | REG_W (8) | Fine high threshold |
| flow_lo | input | REG_W (8) | Fine low threshold |
| cts_n | input | 1 | Peer clear-to-send, primary pin |
| dsr_n | input | 1 | Peer clear-to-send, alternate pin |
| rts_n | output | 1 | Active-low request, primary pin |
| dtr_n | output | 1 | Active-low request, alternate pin |
| tx_clear_n | output | 1 | Selected peer clear-to-send, registered |
| rx_irq | output | 1 | Receive level reached, registered |
| rx_space | output | 1 | FIFO not full |

## Verification
Some properties are checked by the assertions on every cycle:
- withdrawal at or above the high threshold;
- restoration at or below the low threshold;
- holding inside the hysteresis band;
- the forced-on state while flow control is disabled;
- the parking of the unused pin under either swap setting;
- the registered receive comparison.

These assertions work against the threshold values that the selector feeds to the hysteresis stage. They therefore cannot show that the selector picks the right source.

The bench covers that part. It sweeps the count up and down through every value for each coarse table entry and several fine settings. These include the extreme thresholds, inverted thresholds, and fine mode entered only through the transmit level register. The bench compares every pin against thresholds it derives from the requirement tables.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // Coarse-mode threshold pair, indexed by the low half of the trigger field.
  function automatic logic [7:0] coarse_hi(input logic [1:0] idx);
    case (idx)
      2'd0:    coarse_hi = 8'd8;
      2'd1:    coarse_hi = 8'd16;
      2'd2:    coarse_hi = 8'd56;
      default: coarse_hi = 8'd60;
    endcase
  endfunction

  function automatic logic [7:0] coarse_lo(input logic [1:0] idx);
    case (idx)
      2'd0:    coarse_lo = 8'd4;
      2'd1:    coarse_lo = 8'd8;
      2'd2:    coarse_lo = 8'd32;
      default: coarse_lo = 8'd48;
    endcase
  endfunction

  // Coarse-mode receive trigger, indexed by the upper half of the field.
  function automatic logic [7:0] coarse_rx(input logic [1:0] idx);
    case (idx)
      2'd0:    coarse_rx = 8'd8;
      2'd1:    coarse_rx = 8'd16;
      2'd2:    coarse_rx = 8'd56;
      default: coarse_rx = 8'd60;
    endcase
  endfunction

endpackage

// File: rtl/fc_thresh_sel.sv
module fc_thresh_sel #(
  parameter int REG_W = 8
) (
  input  logic [3:0]       trig_sel,
  input  logic [REG_W-1:0] tx_lvl,
  input  logic [REG_W-1:0] rx_lvl,
  input  logic [REG_W-1:0] flow_hi,
  input  logic [REG_W-1:0] flow_lo,
  output logic [REG_W-1:0] hi_thr,
  output logic [REG_W-1:0] lo_thr,
  output logic [REG_W-1:0] rx_trig
);
  import fc_pkg::*;

  localparam int NREG = 4;

  logic [REG_W-1:0] ext_regs [NREG];
  logic [NREG-1:0]  reg_nz;
  logic             fine_mode;

  assign ext_regs[0] = tx_lvl;
  assign ext_regs[1] = rx_lvl;
  assign ext_regs[2] = flow_hi;
  assign ext_regs[3] = flow_lo;

  // One non-zero detector per extended register.
  for (genvar g = 0; g < NREG; g++) begin : g_nz
    assign reg_nz[g] = |ext_regs[g];
  end

  assign fine_mode = |reg_nz;

  always_comb begin
    if (fine_mode) begin
      hi_thr  = flow_hi;
      lo_thr  = flow_lo;
      rx_trig = (rx_lvl == '0) ? REG_W'(1) : rx_lvl;
    end else begin
      hi_thr  = REG_W'(coarse_hi(trig_sel[1:0]));
      lo_thr  = REG_W'(coarse_lo(trig_sel[1:0]));
      rx_trig = REG_W'(coarse_rx(trig_sel[3:2]));
    end
  end

endmodule

// File: rtl/fc_hysteresis.sv
module fc_hysteresis #(
  parameter int CNT_W = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flow_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [REG_W-1:0] hi_thr,
  input  logic [REG_W-1:0] lo_thr,
  input  logic [REG_W-1:0] rx_trig,
  output logic             off_next,
  output logic             flow_off,
  output logic             rx_irq
);
  localparam int CMP_W = ((CNT_W > REG_W) ? CNT_W : REG_W) + 1;

  logic [CMP_W-1:0] cnt_x, hi_x, lo_x, trig_x;

  assign cnt_x  = CMP_W'(rx_count);
  assign hi_x   = CMP_W'(hi_thr);
  assign lo_x   = CMP_W'(lo_thr);
  assign trig_x = CMP_W'(rx_trig);

  // High comparison has priority so an inverted pair still resolves.
  always_comb begin
    if (!flow_en)             off_next = 1'b0;
    else if (cnt_x >= hi_x)   off_next = 1'b1;
    else if (cnt_x <= lo_x)   off_next = 1'b0;
    else                      off_next = flow_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flow_off <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      flow_off <= off_next;
      rx_irq   <= (cnt_x >= trig_x);
    end
  end

endmodule

// File: rtl/fc_pin_map.sv
module fc_pin_map (
  input  logic clk,
  input  logic rst,
  input  logic pin_swap,
  input  logic off_next,
  input  logic cts_n,
  input  logic dsr_n,
  output logic rts_n,
  output logic dtr_n,
  output logic tx_clear_n
);
  // Unused request pin parks high (inactive).
  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n      <= 1'b0;
      dtr_n      <= 1'b1;
      tx_clear_n <= 1'b1;
    end else begin
      rts_n      <= pin_swap ? 1'b1 : off_next;
      dtr_n      <= pin_swap ? off_next : 1'b1;
      tx_clear_n <= pin_swap ? dsr_n : cts_n;
    end
  end

endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl #(
  parameter int DEPTH = 128,
  parameter int REG_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             flow_en,
  input  logic             pin_swap,
  input  logic [3:0]       trig_sel,
  input  logic [REG_W-1:0] tx_lvl,
  input  logic [REG_W-1:0] rx_lvl,
  input  logic [REG_W-1:0] flow_hi,
  input  logic [REG_W-1:0] flow_lo,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_clear_n,
  output logic             rx_irq,
  output logic             rx_space
);
  localparam int SPC_W = CNT_W + 1;

  logic [REG_W-1:0] hi_thr, lo_thr, rx_trig;
  logic             off_next, flow_off;

  fc_thresh_sel #(.REG_W(REG_W)) u_sel (
    .trig_sel (trig_sel),
    .tx_lvl   (tx_lvl),
    .rx_lvl   (rx_lvl),
    .flow_hi  (flow_hi),
    .flow_lo  (flow_lo),
    .hi_thr   (hi_thr),
    .lo_thr   (lo_thr),
    .rx_trig  (rx_trig)
  );

  fc_hysteresis #(.CNT_W(CNT_W), .REG_W(REG_W)) u_hys (
    .clk      (clk),
    .rst      (rst),
    .flow_en  (flow_en),
    .rx_count (rx_count),
    .hi_thr   (hi_thr),
    .lo_thr   (lo_thr),
    .rx_trig  (rx_trig),
    .off_next (off_next),
    .flow_off (flow_off),
    .rx_irq   (rx_irq)
  );

  fc_pin_map u_map (
    .clk        (clk),
    .rst        (rst),
    .pin_swap   (pin_swap),
    .off_next   (off_next),
    .cts_n      (cts_n),
    .dsr_n      (dsr_n),
    .rts_n      (rts_n),
    .dtr_n      (dtr_n),
    .tx_clear_n (tx_clear_n)
  );

  // Reception is limited only by capacity, never by the request state.
  assign rx_space = (SPC_W'(rx_count) < SPC_W'(DEPTH));

endmodule

// File: rtl/fc_checks.sv
module fc_checks #(
  parameter int CNT_W = 8,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             flow_en,
  input logic             pin_swap,
  input logic [CNT_W-1:0] rx_count,
  input logic [REG_W-1:0] hi_thr,
  input logic [REG_W-1:0] lo_thr,
  input logic [REG_W-1:0] rx_trig,
  input logic             flow_off,
  input logic             rts_n,
  input logic             dtr_n,
  input logic             rx_irq
);
  localparam int CW = ((CNT_W > REG_W) ? CNT_W : REG_W) + 1;

  logic [CW-1:0] c, h, l, t;
  assign c = CW'(rx_count);
  assign h = CW'(hi_thr);
  assign l = CW'(lo_thr);
  assign t = CW'(rx_trig);

  p_high_off_r4: assert property (@(posedge clk) disable iff (rst)
    (flow_en && c >= h) |=> flow_off);

  p_low_on_r5: assert property (@(posedge clk) disable iff (rst)
    (flow_en && c <= l && c < h) |=> !flow_off);

  p_band_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (flow_en && c > l && c < h) |=> $stable(flow_off));

  p_disabled_on_r6: assert property (@(posedge clk) disable iff (rst)
    !flow_en |=> !flow_off);

  p_swap_park_r7: assert property (@(posedge clk) disable iff (rst)
    pin_swap |=> (rts_n && dtr_n == flow_off));

  p_plain_park_r7: assert property (@(posedge clk) disable iff (rst)
    !pin_swap |=> (dtr_n && rts_n == flow_off));

  p_one_pin_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~rts_n, ~dtr_n}));

  p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rx_irq == ($past(c) >= $past(t))));

endmodule

bind rx_flow_ctrl fc_checks #(.CNT_W(CNT_W), .REG_W(REG_W)) u_fc_checks (
  .clk      (clk),
  .rst      (rst),
  .flow_en  (flow_en),
  .pin_swap (pin_swap),
  .rx_count (rx_count),
  .hi_thr   (hi_thr),
  .lo_thr   (lo_thr),
  .rx_trig  (rx_trig),
  .flow_off (flow_off),
  .rts_n    (rts_n),
  .dtr_n    (dtr_n),
  .rx_irq   (rx_irq)
);

// File: tb/test_rx_flow_ctrl.sv
module test_rx_flow_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_count = '0;
  logic       flow_en = 1'b0, pin_swap = 1'b0;
  logic [3:0] trig_sel = '0;
  logic [7:0] tx_lvl = '0, rx_lvl = '0, flow_hi = '0, flow_lo = '0;
  logic       cts_n = 1'b0, dsr_n = 1'b0;
  logic       rts_n, dtr_n, tx_clear_n, rx_irq, rx_space;

  int total = 0, failed = 0;
  logic exp_off = 1'b0;

  always #4 clk = ~clk;

  rx_flow_ctrl i_rx_flow_ctrl (
    .clk(clk), .rst(rst), .rx_count(rx_count), .flow_en(flow_en),
    .pin_swap(pin_swap), .trig_sel(trig_sel), .tx_lvl(tx_lvl),
    .rx_lvl(rx_lvl), .flow_hi(flow_hi), .flow_lo(flow_lo),
    .cts_n(cts_n), .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n),
    .tx_clear_n(tx_clear_n), .rx_irq(rx_irq), .rx_space(rx_space)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %b expected %b (count %0d)", tag, act, exp, rx_count);
    end
  endtask

  // Thresholds derived from the requirement tables (R2, R3, R9).
  function automatic int tbl(input int i);
    case (i)
      0: tbl = 8;  1: tbl = 16;  2: tbl = 56;  default: tbl = 60;
    endcase
  endfunction
  function automatic int tbl_lo(input int i);
    case (i)
      0: tbl_lo = 4;  1: tbl_lo = 8;  2: tbl_lo = 32;  default: tbl_lo = 48;
    endcase
  endfunction
  function automatic bit fine();
    fine = (tx_lvl | rx_lvl | flow_hi | flow_lo) != 0;
  endfunction
  function automatic int hi_v();
    hi_v = fine() ? int'(flow_hi) : tbl(int'(trig_sel[1:0]));
  endfunction
  function automatic int lo_v();
    lo_v = fine() ? int'(flow_lo) : tbl_lo(int'(trig_sel[1:0]));
  endfunction
  function automatic int trig_v();
    if (fine()) trig_v = (rx_lvl == 0) ? 1 : int'(rx_lvl);
    else        trig_v = tbl(int'(trig_sel[3:2]));
  endfunction

  task automatic step(input int c, input string ftag);
    logic exp_irq;
    @(negedge clk);
    rx_count = c[7:0];
    #1;
    chk("R10 rx_space", rx_space, c < 128);
    if (!flow_en)           exp_off = 1'b0;
    else if (c >= hi_v())   exp_off = 1'b1;
    else if (c <= lo_v())   exp_off = 1'b0;
    exp_irq = (c >= trig_v());
    @(negedge clk);
    chk(ftag, pin_swap ? dtr_n : rts_n, exp_off);
    chk("R7 parked pin", pin_swap ? rts_n : dtr_n, 1'b1);
    chk("R9 rx_irq", rx_irq, exp_irq);
  endtask

  task automatic sweep(input string ftag);
    for (int c = 0; c <= 128; c++) step(c, ftag);
    for (int c = 127; c >= 0; c--) step(c, ftag);
  endtask

  task automatic fine_cfg(input int tx, input int rx, input int h, input int l);
    tx_lvl = tx[7:0]; rx_lvl = rx[7:0]; flow_hi = h[7:0]; flow_lo = l[7:0];
    step(0, "R2 settle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    // R1: reset values, with cts_n low so tx_clear_n=1 is distinguishable
    repeat (3) @(negedge clk);
    chk("R1 rts_n", rts_n, 1'b0);
    chk("R1 dtr_n", dtr_n, 1'b1);
    chk("R1 tx_clear_n", tx_clear_n, 1'b1);
    chk("R1 rx_irq", rx_irq, 1'b0);
    rst = 1'b0;

    // R6: disabled flow control keeps request on
    step(0, "R6 disabled");
    sweep("R6 disabled");

    // R3, R4, R5: coarse table entries
    flow_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      trig_sel = {2'(3 - i), 2'(i)};
      step(0, "R3 settle");
      sweep("R3 R4 R5 coarse hysteresis");
    end

    // R6: drop enable while withdrawn
    step(100, "R4 withdrawn");
    flow_en = 1'b0;
    step(100, "R6 disable while withdrawn");
    flow_en = 1'b1;

    // R2: fine mode entered through the transmit level register only
    fine_cfg(5, 0, 0, 0);
    sweep("R2 R12 fine via tx_lvl");

    // R2, R11: fine thresholds, extremes
    fine_cfg(0, 0, 20, 10);
    sweep("R2 R4 R5 fine 20/10");
    fine_cfg(0, 128, 128, 1);
    sweep("R11 fine 128/1");
    fine_cfg(0, 3, 2, 1);
    sweep("R11 fine 2/1");

    // R12: equal and inverted thresholds
    fine_cfg(0, 7, 5, 5);
    sweep("R12 equal thresholds");
    fine_cfg(0, 0, 3, 9);
    sweep("R12 inverted thresholds");

    // R7: swapped pins
    pin_swap = 1'b1;
    fine_cfg(0, 40, 30, 12);
    sweep("R7 swapped pin");
    flow_en = 1'b0;
    step(64, "R6 R7 swapped disabled");
    flow_en = 1'b1;

    // R8: clear-to-send source follows the swap bit
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 4; v++) begin
        @(negedge clk);
        pin_swap = s[0]; cts_n = v[0]; dsr_n = v[1];
        @(negedge clk);
        chk("R8 tx_clear_n", tx_clear_n, s[0] ? v[1] : v[0]);
      end
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule